// File: doc/BRIEF.md
# Stacked-Die Access Router

This block is the control slice that sits inside each die of a two-die flash stack sharing one chip enable. Every die receives the same host access and holds its own copy of two start-address registers. From a strap input, each die learns whether it is the first (strap low) or the second (strap high) die. It then decides for itself whether to answer each access. Register writes land in both dies. Register reads and data-RAM traffic go only to the die whose identity equals the stored buffer-select bit. Boot-RAM traffic always goes to the first die.

The host address is decoded into four regions: boot RAM `0000h`-`01FFh`, data RAM `0200h`-`0FFFh`, register space `F000h`-`FFFFh`, and unmapped (everything else). A small read state machine has the following states:

- `ST_IDLE`: no read data is driven.
- `ST_DRV_REG`: the die drives a captured register value.
- `ST_DRV_BUF`: the die drives its buffer RAM's synchronous read data.

It has the following transitions:

- *reg-hit*: from any state to `ST_DRV_REG` on a served register read.
- *buf-hit*: from any state to `ST_DRV_BUF` on a served boot or data read.
- *release*: to `ST_IDLE` on any cycle without a served read.

Because every state accepts a new request, back-to-back reads are supported. The block also exposes the stored 12-bit block number and a flag telling whether this die's flash core is the one addressed. It raises an error pulse when a double-plane program is started on an odd block.

Top module: `dual_die_route`

## Requirements
- R1: After reset both start-address registers are zero, `rd_oe`, `plane_err` and all strobes are low, and `blk_addr` is zero.
- R2: Register `F100h` keeps bit 15 as the core-select bit and bits 10:0 as the block address; bits 14:11 read as zero, and writes to them are dropped.
- R3: Register `F101h` keeps bit 15 as the buffer-select bit; bits 14:0 read as zero.
- R4: A register write updates both dies whatever the buffer-select value.
- R5: A read anywhere in register space is driven only by the die whose strap equals the buffer-select bit; a strap of 0 matches a select of 0.
- R6: Boot-region reads and writes are served only by the die with strap 0, regardless of buffer-select.
- R7: Data-region reads and writes are served only by the die whose strap equals buffer-select; the other die raises no strobe and drives nothing.
- R8: `buf_rd` is raised in the request cycle of a served buffer read. `rd_oe` and `rd_data` are valid in the following cycle only, unless another served read follows.
- R9: Unmapped addresses, `1000h`-`EFFFh`, cause no strobe and no drive. Register-space addresses other than `F100h`/`F101h` read as zero and ignore writes.
- R10: `blk_addr` equals {core-select, block address}, and `core_sel` is high exactly when core-select equals the strap.
- R11: `plane_err` pulses high in the cycle after `cmd_dual_plane` when the stored block address bit 0 is 1, and stays low when it is 0.
- R12: When `host_we` and `host_re` are both high, the write is performed and the read is ignored.
- R13: Two dies with opposite straps on one bus never assert `rd_oe` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| die_strap | input | 1 | Die identity: 0 first die, 1 second die |
| acc_en | input | 1 | Shared access enable |
| host_re | input | 1 | Read request |
| host_we | input | 1 | Write request |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| ram_rdata | input | 16 | Buffer RAM read data, one cycle after `buf_rd` |
| cmd_dual_plane | input | 1 | Double-plane program command issued |
| rd_oe | output | 1 | This die drives the read bus |
| rd_data | output | 16 | Read data while `rd_oe` |
| buf_rd | output | 1 | Buffer RAM read strobe |
| boot_we | output | 1 | Boot RAM write strobe |
| data_we | output | 1 | Data RAM write strobe |
| core_sel | output | 1 | This die's flash core is addressed |
| blk_addr | output | 12 | Stored {core-select, block address} |
| plane_err | output | 1 | Odd block on double-plane command |

## Verification
On every cycle, the assertions check the following:

- Drive only follows an accepted read to a mapped region.
- A simultaneous read and write never produces drive.
- Boot writes come only from the strap-0 die.
- Buffer-select and core-select follow the write data of the cycle before.
- Error pulses are always preceded by the command.

Only the bench, with two dies sharing one bus, can show the following:

- Writes are broadcast.
- Exactly one die answers each read.
- The returned values and reserved-bit masking are correct.

// File: rtl/dd_route_pkg.sv
package dd_route_pkg;
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_BOOT = 2'd1,
        RG_DATA = 2'd2,
        RG_REG  = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRV_REG = 2'd1,
        ST_DRV_BUF = 2'd2
    } rd_state_t;
endpackage

// File: rtl/dd_addr_decode.sv
module dd_addr_decode
    import dd_route_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BOOT_LO    = 'h0000,
    parameter int BOOT_HI    = 'h01FF,
    parameter int DATA_LO    = 'h0200,
    parameter int DATA_HI    = 'h0FFF,
    parameter int REG_LO     = 'hF000,
    parameter int REG_HI     = 'hFFFF,
    parameter int REG_A_ADDR = 'hF100,
    parameter int REG_B_ADDR = 'hF101
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic              sel_a,
    output logic              sel_b
);
    localparam logic [ADDR_W-1:0] B_LO = ADDR_W'(BOOT_LO);
    localparam logic [ADDR_W-1:0] B_HI = ADDR_W'(BOOT_HI);
    localparam logic [ADDR_W-1:0] D_LO = ADDR_W'(DATA_LO);
    localparam logic [ADDR_W-1:0] D_HI = ADDR_W'(DATA_HI);
    localparam logic [ADDR_W-1:0] R_LO = ADDR_W'(REG_LO);
    localparam logic [ADDR_W-1:0] R_HI = ADDR_W'(REG_HI);
    localparam logic [ADDR_W-1:0] A_AD = ADDR_W'(REG_A_ADDR);
    localparam logic [ADDR_W-1:0] B_AD = ADDR_W'(REG_B_ADDR);

    logic in_boot, in_data, in_reg;

    always_comb begin
        in_boot = (addr >= B_LO) && (addr <= B_HI);
        in_data = (addr >= D_LO) && (addr <= D_HI);
        in_reg  = (addr >= R_LO) && (addr <= R_HI);
        if (in_boot)      region = RG_BOOT;
        else if (in_data) region = RG_DATA;
        else if (in_reg)  region = RG_REG;
        else              region = RG_NONE;
        sel_a = in_reg && (addr == A_AD);
        sel_b = in_reg && (addr == B_AD);
    end
endmodule

// File: rtl/dd_start_regs.sv
module dd_start_regs #(
    parameter int DATA_W = 16,
    parameter int BLK_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              cmd_dual_plane,
    output logic              dfs,
    output logic              dbs,
    output logic [BLK_W-1:0]  fba,
    output logic [DATA_W-1:0] rdata,
    output logic              plane_err
);
    localparam int RSV_A_W = DATA_W - 1 - BLK_W;
    localparam int RSV_B_W = DATA_W - 1;

    logic             dfs_q, dbs_q, err_q;
    logic [BLK_W-1:0] fba_q;
    logic             unused_rsv;

    assign unused_rsv = ^wdata[DATA_W-2:BLK_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dfs_q <= 1'b0;
            dbs_q <= 1'b0;
            fba_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_a) begin
                dfs_q <= wdata[DATA_W-1];
                fba_q <= wdata[BLK_W-1:0];
            end
            if (wr_b) begin
                dbs_q <= wdata[DATA_W-1];
            end
            err_q <= cmd_dual_plane && fba_q[0];
        end
    end

    always_comb begin
        if (sel_a)      rdata = {dfs_q, {RSV_A_W{1'b0}}, fba_q};
        else if (sel_b) rdata = {dbs_q, {RSV_B_W{1'b0}}};
        else            rdata = '0;
    end

    assign dfs       = dfs_q;
    assign dbs       = dbs_q;
    assign fba       = fba_q;
    assign plane_err = err_q;

    p_dbs_follows_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> (dbs_q == $past(wdata[DATA_W-1])));
    p_dfs_follows_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (dfs_q == $past(wdata[DATA_W-1])));
    p_err_needs_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(cmd_dual_plane));
endmodule

// File: rtl/dd_select.sv
module dd_select
    import dd_route_pkg::*;
(
    input  logic    strap,
    input  logic    dbs,
    input  logic    dfs,
    input  region_t region,
    output logic    serve,
    output logic    core_sel
);
    logic buf_match;

    always_comb begin
        buf_match = (dbs == strap);
        core_sel  = (dfs == strap);
        unique case (region)
            RG_BOOT: serve = !strap;
            RG_DATA: serve = buf_match;
            RG_REG:  serve = buf_match;
            default: serve = 1'b0;
        endcase
    end
endmodule

// File: rtl/dd_access_fsm.sv
module dd_access_fsm
    import dd_route_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              host_re,
    input  logic              host_we,
    input  region_t           region,
    input  logic              serve,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              rd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_rd,
    output logic              boot_we,
    output logic              data_we,
    output logic              reg_wr
);
    rd_state_t         state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              rd_req, wr_req;

    always_comb begin
        wr_req  = acc_en && host_we;
        rd_req  = acc_en && host_re && !host_we;
        reg_wr  = wr_req && (region == RG_REG);
        boot_we = wr_req && serve && (region == RG_BOOT);
        data_we = wr_req && serve && (region == RG_DATA);
        buf_rd  = rd_req && serve && ((region == RG_BOOT) || (region == RG_DATA));
        state_d = ST_IDLE;
        if (rd_req && serve) begin
            unique case (region)
                RG_REG:  state_d = ST_DRV_REG;
                RG_BOOT: state_d = ST_DRV_BUF;
                RG_DATA: state_d = ST_DRV_BUF;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_DRV_REG) hold_q <= reg_rdata;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DRV_REG: begin
                rd_oe   = 1'b1;
                rd_data = hold_q;
            end
            ST_DRV_BUF: begin
                rd_oe   = 1'b1;
                rd_data = ram_rdata;
            end
            default: begin
                rd_oe   = 1'b0;
                rd_data = '0;
            end
        endcase
    end

    p_oe_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(acc_en && host_re && !host_we));
    p_no_drive_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(region != RG_NONE));
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && host_we) |=> !rd_oe);
endmodule

// File: rtl/dual_die_route.sv
module dual_die_route
    import dd_route_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              die_strap,
    input  logic              acc_en,
    input  logic              host_re,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              cmd_dual_plane,
    output logic              rd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_rd,
    output logic              boot_we,
    output logic              data_we,
    output logic              core_sel,
    output logic [BLK_W:0]    blk_addr,
    output logic              plane_err
);
    region_t           region;
    logic              sel_a, sel_b, reg_wr, serve;
    logic              dfs, dbs;
    logic [BLK_W-1:0]  fba;
    logic [DATA_W-1:0] reg_rdata;

    dd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (host_addr),
        .region(region),
        .sel_a (sel_a),
        .sel_b (sel_b)
    );

    dd_start_regs #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_a          (reg_wr && sel_a),
        .wr_b          (reg_wr && sel_b),
        .wdata         (host_wdata),
        .sel_a         (sel_a),
        .sel_b         (sel_b),
        .cmd_dual_plane(cmd_dual_plane),
        .dfs           (dfs),
        .dbs           (dbs),
        .fba           (fba),
        .rdata         (reg_rdata),
        .plane_err     (plane_err)
    );

    dd_select u_sel (
        .strap   (die_strap),
        .dbs     (dbs),
        .dfs     (dfs),
        .region  (region),
        .serve   (serve),
        .core_sel(core_sel)
    );

    dd_access_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .host_re  (host_re),
        .host_we  (host_we),
        .region   (region),
        .serve    (serve),
        .reg_rdata(reg_rdata),
        .ram_rdata(ram_rdata),
        .rd_oe    (rd_oe),
        .rd_data  (rd_data),
        .buf_rd   (buf_rd),
        .boot_we  (boot_we),
        .data_we  (data_we),
        .reg_wr   (reg_wr)
    );

    assign blk_addr = {dfs, fba};

    p_boot_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_we || (buf_rd && region == RG_BOOT)) |-> !die_strap);
    p_data_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |-> (dbs == die_strap));
endmodule

// File: tb/tb_dual_die_route.sv
`timescale 1ns/100ps
module tb_dual_die_route;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, host_re = 1'b0, host_we = 1'b0, cmd = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] ram1, ram2, d1, d2, bus;
    logic        oe1, oe2, brd1, brd2, bwe1, bwe2, dwe1, dwe2, cs1, cs2, er1, er2;
    logic [11:0] ba1, ba2;
    int          total = 0, bad = 0, overlap = 0;

    always #2.5 clk = ~clk;

    dual_die_route dut (
        .clk(clk), .rst_n(rst_n), .die_strap(1'b0), .acc_en(acc_en),
        .host_re(host_re), .host_we(host_we), .host_addr(addr),
        .host_wdata(wdata), .ram_rdata(ram1), .cmd_dual_plane(cmd),
        .rd_oe(oe1), .rd_data(d1), .buf_rd(brd1), .boot_we(bwe1),
        .data_we(dwe1), .core_sel(cs1), .blk_addr(ba1), .plane_err(er1));

    dual_die_route dut_b (
        .clk(clk), .rst_n(rst_n), .die_strap(1'b1), .acc_en(acc_en),
        .host_re(host_re), .host_we(host_we), .host_addr(addr),
        .host_wdata(wdata), .ram_rdata(ram2), .cmd_dual_plane(cmd),
        .rd_oe(oe2), .rd_data(d2), .buf_rd(brd2), .boot_we(bwe2),
        .data_we(dwe2), .core_sel(cs2), .blk_addr(ba2), .plane_err(er2));

    always_ff @(posedge clk) begin
        if (brd1) ram1 <= addr ^ 16'h5000;
        if (brd2) ram2 <= addr ^ 16'hA000;
    end

    assign bus = oe1 ? d1 : (oe2 ? d2 : 16'h0000);

    always @(negedge clk) if (rst_n && oe1 && oe2) overlap++;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic rd, input logic [15:0] a, input logic [15:0] d);
        acc_en = 1'b1; host_we = wr; host_re = rd; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; host_we = 1'b0; host_re = 1'b0;
    endtask

    // {wr, addr, wdata, exp_oe1, exp_oe2, exp_bus}
    localparam logic [50:0] VECS [0:17] = '{
        {1'b0, 16'hF100, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {1'b1, 16'hF100, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
        {1'b0, 16'hF100, 16'h0000, 1'b1, 1'b0, 16'h87FF},
        {1'b1, 16'hF101, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
        {1'b0, 16'hF101, 16'h0000, 1'b0, 1'b1, 16'h8000},
        {1'b0, 16'hF100, 16'h0000, 1'b0, 1'b1, 16'h87FF},
        {1'b0, 16'h0010, 16'h0000, 1'b1, 1'b0, 16'h5010},
        {1'b0, 16'h0300, 16'h0000, 1'b0, 1'b1, 16'hA300},
        {1'b0, 16'hF002, 16'h0000, 1'b0, 1'b1, 16'h0000},
        {1'b1, 16'hF002, 16'h1234, 1'b0, 1'b0, 16'h0000},
        {1'b0, 16'hF100, 16'h0000, 1'b0, 1'b1, 16'h87FF},
        {1'b1, 16'hF101, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {1'b0, 16'h0300, 16'h0000, 1'b1, 1'b0, 16'h5300},
        {1'b0, 16'h2000, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {1'b1, 16'hF100, 16'h0ABC, 1'b0, 1'b0, 16'h0000},
        {1'b0, 16'hF100, 16'h0000, 1'b1, 1'b0, 16'h02BC},
        {1'b0, 16'h01FF, 16'h0000, 1'b1, 1'b0, 16'h51FF},
        {1'b0, 16'h0200, 16'h0000, 1'b1, 1'b0, 16'h5200}
    };

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 oe", {oe1, oe2}, 2'b00);
        chk("R1 blk", {ba1, ba2}, 24'h0);
        chk("R1 err/strobes", {er1, er2, bwe1, bwe2, dwe1, dwe2, brd1, brd2}, 8'h0);
        chk("R10 core_sel reset", {cs1, cs2}, 2'b10);

        // vector walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < 18; i++) begin
            logic [50:0] v;
            v = VECS[i];
            issue(v[50], !v[50], v[49:34], v[33:18]);
            if (!v[50]) begin
                chk($sformatf("R5/R6/R7 vec%0d oe", i), {oe1, oe2}, v[17:16]);
                chk($sformatf("R2/R3/R9 vec%0d data", i), bus, v[15:0]);
            end
        end

        // R8: drive lasts one cycle only
        @(negedge clk);
        chk("R8 oe released", {oe1, oe2}, 2'b00);

        // R8: buf_rd in request cycle (dbs=0, data region -> die 1)
        acc_en = 1'b1; host_re = 1'b1; addr = 16'h0400; #1;
        chk("R8 buf_rd request cycle", {brd1, brd2}, 2'b10);
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0; host_re = 1'b0;
        chk("R8 buf data next cycle", bus, 16'h5400);

        // R10: blk_addr and core_sel
        chk("R10 blk_addr", {ba1, ba2}, {12'h2BC, 12'h2BC});
        issue(1'b1, 1'b0, 16'hF100, 16'h8001);
        chk("R10 blk_addr dfs", {ba1, ba2}, {12'h801, 12'h801});
        chk("R10 core_sel dfs=1", {cs1, cs2}, 2'b01);

        // R11: odd block plane error
        cmd = 1'b1; @(posedge clk); @(negedge clk); cmd = 1'b0;
        chk("R11 err odd block", {er1, er2}, 2'b11);
        @(negedge clk);
        chk("R11 err is a pulse", {er1, er2}, 2'b00);
        issue(1'b1, 1'b0, 16'hF100, 16'h0002);
        cmd = 1'b1; @(posedge clk); @(negedge clk); cmd = 1'b0;
        chk("R11 no err even block", {er1, er2}, 2'b00);

        // R7 write strobes (dbs=0)
        acc_en = 1'b1; host_we = 1'b1; addr = 16'h0300; #1;
        chk("R7 data_we die1 only", {dwe1, dwe2}, 2'b10);
        @(posedge clk); @(negedge clk); acc_en = 1'b0; host_we = 1'b0;

        // R12: write+read together, set dbs=1
        acc_en = 1'b1; host_we = 1'b1; host_re = 1'b1; addr = 16'hF101; wdata = 16'h8000;
        @(posedge clk); @(negedge clk);
        acc_en = 1'b0; host_we = 1'b0; host_re = 1'b0;
        chk("R12 read ignored", {oe1, oe2}, 2'b00);
        issue(1'b0, 1'b1, 16'hF101, 16'h0);
        chk("R12 write done", bus, 16'h8000);
        chk("R4 die2 answers", {oe1, oe2}, 2'b01);

        // R6 boot write with dbs=1, R7 data write now die2
        acc_en = 1'b1; host_we = 1'b1; addr = 16'h0004; #1;
        chk("R6 boot_we die1 only", {bwe1, bwe2}, 2'b10);
        addr = 16'h0800; #1;
        chk("R7 data_we die2 only", {dwe1, dwe2}, 2'b01);
        addr = 16'h3000; #1;
        chk("R9 no strobe unmapped", {bwe1, bwe2, dwe1, dwe2}, 4'h0);
        @(posedge clk); @(negedge clk); acc_en = 1'b0; host_we = 1'b0;

        // R13: bus overlap never seen
        chk("R13 overlap", overlap, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule